// File: doc/BRIEF.md
# Multi-mode 8-bit timer with compare flags

An 8-bit counter with two compare channels, driven from a small register bus. Software chooses one of four counting modes: plain wrap, wrap at a programmable top, count down with reload, or count up and then back down. The block holds a sticky flag per channel plus an overflow flag. It emits a one-cycle DMA trigger per channel whenever the counter matches that channel's value. It raises an interrupt request while any channel flag is set and that channel is unmasked.

The rules for setting flags depend on the mode. In the up/down mode, the channel 0 flag is no longer a compare flag. It is set together with the overflow flag when the counter reverses direction at zero. Channel 0's value also serves as the top or reload value in the modulo, down and up/down modes.

Top module: `mm_timer8`

## Requirements
- R1: After reset the counter, control, channel values, masks and flags all read 0, and `irq_o` and `dma_trig_o` are low.
- R2: The register addresses are: 0 counter, 1 control, 2 flags, 3 ch0 control, 4 ch0 value, 5 ch1 control, 6 ch1 value. Bit 0 of a channel control register is its mask, and the other bits of that register read 0. Writes to address 0 have no effect on the counter.
- R3: Control bit 0 is run, and bits 2:1 select the mode: 00 free, 01 modulo, 10 down, 11 up/down. While run is 0 the counter holds and no compare or overflow events occur.
- R4: A control write with bit 3 set clears the counter to 0 and the direction to up on that edge. It leaves run and mode unchanged, and bit 3 reads back as 0.
- R5: In free mode the counter increments each cycle and wraps from 0xFF to 0x00. The overflow flag is set on the edge that follows a cycle in which the counter is 0xFF.
- R6: In modulo mode the counter goes 0, 1, ... up to the ch0 value and then back to 0. The overflow flag is set on the edge at which it leaves the ch0 value.
- R7: In down mode the counter decrements, and from 0 it reloads the ch0 value. The overflow flag is set on the edge at which it leaves 0.
- R8: In up/down mode the counter counts up to the ch0 value and then down to 0. The ch0 flag and the overflow flag are set only on the edge at which it turns around at 0 while descending. A ch0 match does not set either flag, and the start from 0 going up does not set them.
- R9: Flag register bits are bit 0 ch0, bit 1 ch1 and bit 2 overflow. The ch1 flag is set in all modes, and the ch0 flag in every mode except up/down, on the edge after a cycle in which the running counter equals that channel's value.
- R10: `dma_trig_o[n]` is high exactly in the cycles in which the counter is running and equals the channel n value, in every mode.
- R11: Flags are sticky. Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. If a set event and a clearing write fall on the same edge, the flag ends up set.
- R12: `irq_o` is high exactly when at least one channel has both its flag and its mask set. The overflow flag does not affect `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| dma_trig_o | output | 2 | Per-channel compare trigger pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a flag-clearing write that lands on the same edge as that flag's set event. The bench runs the counter in free mode, polls the ch1 trigger at each falling edge, and issues the clearing write in the very cycle the trigger is seen, so that the write commits on the setting edge. The up/down test is the other delicate case. It walks the counter through a whole up-down period cycle by cycle and checks that the ch0 flag stays clear across the ch0 match and sets only after the descent reaches zero.

// File: rtl/mmt_pkg.sv
package mmt_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_MOD  = 2'd1,
    MODE_DOWN = 2'd2,
    MODE_UPDN = 2'd3
  } mode_e;

  localparam int unsigned CTL_RUN_BIT  = 0;
  localparam int unsigned CTL_MODE_LSB = 1;
  localparam int unsigned CTL_CLR_BIT  = 3;

  localparam int unsigned ADDR_CNT     = 0;
  localparam int unsigned ADDR_CTL     = 1;
  localparam int unsigned ADDR_FLG     = 2;
  localparam int unsigned ADDR_CH_BASE = 3;  // per channel: ctl, then value
endpackage

// File: rtl/mmt_counter.sv
module mmt_counter
  import mmt_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         clr_i,
  input  mode_e        mode_i,
  input  logic [W-1:0] top_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_evt_o,
  output logic         turn_evt_o
);
  localparam logic [W-1:0] MaxV = {W{1'b1}};
  localparam logic [W-1:0] OneV = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         dn_q, dn_d;

  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q;
    if (clr_i) begin
      cnt_d = '0;
      dn_d  = 1'b0;
    end else if (run_i) begin
      case (mode_i)
        MODE_FREE: cnt_d = cnt_q + OneV;
        MODE_MOD:  cnt_d = (cnt_q >= top_i) ? '0 : cnt_q + OneV;
        MODE_DOWN: cnt_d = (cnt_q == '0) ? top_i : cnt_q - OneV;
        default: begin
          if (!dn_q) begin
            if (cnt_q >= top_i) begin
              dn_d  = 1'b1;
              cnt_d = (cnt_q == '0) ? '0 : cnt_q - OneV;
            end else begin
              cnt_d = cnt_q + OneV;
            end
          end else if (cnt_q == '0) begin
            dn_d  = 1'b0;
            cnt_d = (top_i == '0) ? '0 : OneV;
          end else begin
            cnt_d = cnt_q - OneV;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  assign turn_evt_o = run_i && (mode_i == MODE_UPDN) && dn_q && (cnt_q == '0);

  always_comb begin
    ovf_evt_o = 1'b0;
    if (run_i) begin
      case (mode_i)
        MODE_FREE: ovf_evt_o = (cnt_q == MaxV);
        MODE_MOD:  ovf_evt_o = (cnt_q >= top_i);
        MODE_DOWN: ovf_evt_o = (cnt_q == '0);
        default:   ovf_evt_o = turn_evt_o;
      endcase
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/mmt_channel.sv
module mmt_channel #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ctl_we_i,
  input  logic         val_we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cnt_i,
  input  logic         run_i,
  output logic [W-1:0] val_o,
  output logic         mask_o,
  output logic         hit_o
);
  logic [W-1:0] val_q;
  logic         mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q  <= '0;
      mask_q <= 1'b0;
    end else begin
      if (ctl_we_i) mask_q <= wdata_i[0];
      if (val_we_i) val_q <= wdata_i;
    end
  end

  assign hit_o  = run_i && (cnt_i == val_q);
  assign val_o  = val_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/mmt_flags.sv
module mmt_flags #(
  parameter int unsigned NF = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] set_i,
  input  logic          we_i,
  input  logic [NF-1:0] wdata_i,
  output logic [NF-1:0] flags_o
);
  logic [NF-1:0] flags_q, keep;

  // writing 0 clears, writing 1 keeps; a set event wins
  assign keep = we_i ? wdata_i : {NF{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & keep) | set_i;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/mm_timer8.sv
module mm_timer8
  import mmt_pkg::*;
#(
  parameter  int unsigned W       = 8,
  parameter  int unsigned NUM_CH  = 2,
  localparam int unsigned NUM_REG = ADDR_CH_BASE + 2 * NUM_CH,
  localparam int unsigned ADDR_W  = $clog2(NUM_REG),
  localparam int unsigned NF      = NUM_CH + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  output logic [W-1:0]      rdata_o,
  output logic [NUM_CH-1:0] dma_trig_o,
  output logic              irq_o
);
  logic              ctl_we, flg_we, clr;
  logic              run_q;
  mode_e             mode_q;
  logic [W-1:0]      cnt;
  logic              ovf_evt, turn_evt;
  logic [NUM_CH-1:0] hit, mask;
  logic [W-1:0]      val [NUM_CH];
  logic [NF-1:0]     flag_set, flags;

  assign ctl_we = wr_en_i && (addr_i == ADDR_W'(ADDR_CTL));
  assign flg_we = wr_en_i && (addr_i == ADDR_W'(ADDR_FLG));
  assign clr    = ctl_we && wdata_i[CTL_CLR_BIT];

  // a clear request leaves run and mode as they were
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      mode_q <= MODE_FREE;
    end else if (ctl_we && !wdata_i[CTL_CLR_BIT]) begin
      run_q  <= wdata_i[CTL_RUN_BIT];
      mode_q <= mode_e'(wdata_i[CTL_MODE_LSB +: 2]);
    end
  end

  mmt_counter #(.W(W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run_q),
    .clr_i      (clr),
    .mode_i     (mode_q),
    .top_i      (val[0]),
    .cnt_o      (cnt),
    .ovf_evt_o  (ovf_evt),
    .turn_evt_o (turn_evt)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    mmt_channel #(.W(W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ctl_we_i (wr_en_i && (addr_i == ADDR_W'(ADDR_CH_BASE + 2 * i))),
      .val_we_i (wr_en_i && (addr_i == ADDR_W'(ADDR_CH_BASE + 2 * i + 1))),
      .wdata_i  (wdata_i),
      .cnt_i    (cnt),
      .run_i    (run_q),
      .val_o    (val[i]),
      .mask_o   (mask[i]),
      .hit_o    (hit[i])
    );
    if (i == 0) begin : g_ch0
      assign flag_set[i] = (mode_q == MODE_UPDN) ? turn_evt : hit[i];
    end else begin : g_chn
      assign flag_set[i] = hit[i];
    end
  end
  assign flag_set[NUM_CH] = ovf_evt;

  mmt_flags #(.NF(NF)) u_flg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (flag_set),
    .we_i    (flg_we),
    .wdata_i (wdata_i[NF-1:0]),
    .flags_o (flags)
  );

  assign dma_trig_o = hit;
  assign irq_o      = |(flags[NUM_CH-1:0] & mask);

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_CNT)) rdata_o = cnt;
    if (addr_i == ADDR_W'(ADDR_CTL)) rdata_o = W'({mode_q, run_q});
    if (addr_i == ADDR_W'(ADDR_FLG)) rdata_o = W'(flags);
    for (int i = 0; i < NUM_CH; i++) begin
      if (addr_i == ADDR_W'(ADDR_CH_BASE + 2 * i))     rdata_o = W'(mask[i]);
      if (addr_i == ADDR_W'(ADDR_CH_BASE + 2 * i + 1)) rdata_o = val[i];
    end
  end
endmodule

// File: rtl/mmt_checker.sv
module mmt_checker
  import mmt_pkg::*;
#(
  parameter  int unsigned W       = 8,
  parameter  int unsigned NUM_CH  = 2,
  localparam int unsigned NUM_REG = ADDR_CH_BASE + 2 * NUM_CH,
  localparam int unsigned ADDR_W  = $clog2(NUM_REG),
  localparam int unsigned NF      = NUM_CH + 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [W-1:0]      wdata_i,
  input logic [W-1:0]      cnt_i,
  input logic              run_i,
  input logic [1:0]        mode_i,
  input logic [W-1:0]      val0_i,
  input logic [NF-1:0]     flags_i,
  input logic [NUM_CH-1:0] dma_i,
  input logic              irq_i
);
  logic ctl_we, flg_we;
  assign ctl_we = wr_en_i && (addr_i == ADDR_W'(ADDR_CTL));
  assign flg_we = wr_en_i && (addr_i == ADDR_W'(ADDR_FLG));

  AST_CNT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !ctl_we |=> $stable(cnt_i)); // R3
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we && wdata_i[CTL_CLR_BIT] |=> cnt_i == '0); // R4
  AST_CLR_KEEPS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_we && wdata_i[CTL_CLR_BIT] |=> $stable(mode_i) && $stable(run_i)); // R4
  AST_FREE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && mode_i == 2'd0 && !ctl_we |=> cnt_i == W'($past(cnt_i) + 1'b1)); // R5
  AST_MOD_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && mode_i == 2'd1 && cnt_i == val0_i && !ctl_we |=> cnt_i == '0); // R6
  AST_DOWN_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && mode_i == 2'd2 && cnt_i == '0 && !ctl_we |=> cnt_i == $past(val0_i)); // R7
  AST_NO_TRIG_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> dma_i == '0); // R10
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> |flags_i[NUM_CH-1:0]); // R12

  for (genvar k = 0; k < NF; k++) begin : g_sticky
    AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags_i[k] && !flg_we |=> flags_i[k]); // R11
  end
endmodule

bind mm_timer8 mmt_checker #(.W(W), .NUM_CH(NUM_CH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .cnt_i   (cnt),
  .run_i   (run_q),
  .mode_i  (mode_q),
  .val0_i  (val[0]),
  .flags_i (flags),
  .dma_i   (dma_trig_o),
  .irq_i   (irq_o)
);

// File: tb/mm_timer8_tb.sv
module mm_timer8_tb;
  localparam int PERIOD = 20;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [1:0] dma_trig_o;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD / 2) clk_i = ~clk_i;

  mm_timer8 u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .dma_trig_o (dma_trig_o),
    .irq_o      (irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(0, v); chk("R1 counter", v, 0);
    rd(1, v); chk("R1 control", v, 0);
    rd(2, v); chk("R1 flags", v, 0);
    rd(4, v); chk("R1 ch0 value", v, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 dma", dma_trig_o, 0);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(0, 8'h55);
    rd(0, v); chk("R2 counter read-only", v, 0);
    wr(6, 8'h5A);
    rd(6, v); chk("R2 ch1 value readback", v, 8'h5A);
    wr(3, 8'hFF);
    rd(3, v); chk("R2 ch0 ctl mask only", v, 8'h01);
    wr(3, 8'h00);
  endtask

  task automatic t_stopped;
    logic [7:0] v;
    wr(6, 8'h00);
    repeat (5) @(negedge clk_i);
    rd(0, v); chk("R3 counter holds while stopped", v, 0);
    chk("R10 no trigger while stopped", dma_trig_o, 0);
    rd(2, v); chk("R3 no flags while stopped", v, 0);
  endtask

  task automatic t_free;
    logic [7:0] v;
    int n;
    wr(6, 8'h05); wr(5, 8'h01); wr(2, 8'h00);
    wr(1, 8'h01);
    n = 0;
    while (!dma_trig_o[1] && n < 50) begin @(negedge clk_i); n++; end
    chk("R10 ch1 trigger seen", dma_trig_o[1], 1);
    rd(0, v); chk("R10 trigger at ch1 value", v, 8'h05);
    for (int k = 1; k <= 256; k++) begin
      @(negedge clk_i);
      if (k == 1) begin
        chk("R10 single-cycle pulse", dma_trig_o[1], 0);
        rd(2, v); chk("R9 ch1 flag set", v[1], 1);
        chk("R12 irq with ch1 masked in", irq_o, 1);
      end
      if (k == 250) begin
        rd(0, v); chk("R5 counter at FF", v, 8'hFF);
        rd(2, v); chk("R5 no overflow before wrap", v[2], 0);
      end
      if (k == 251) begin
        rd(0, v); chk("R5 wrap to 00", v, 8'h00);
        rd(2, v); chk("R5 overflow flag after FF", v[2], 1);
      end
      if (k == 256) chk("R5 period 256", dma_trig_o[1], 1);
    end
    wr(1, 8'h00);
  endtask

  task automatic t_priority;
    logic [7:0] v;
    int n;
    wr(1, 8'h08);
    rd(0, v); chk("R4 clear while stopped", v, 0);
    wr(2, 8'h00);
    rd(2, v); chk("R11 writing 0 clears", v, 0);
    wr(6, 8'h03);
    wr(1, 8'h01);
    n = 0;
    while (!dma_trig_o[1] && n < 50) begin @(negedge clk_i); n++; end
    wr_en_i = 1'b1; addr_i = 3'd2; wdata_i = 8'h00;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    rd(2, v); chk("R11 set wins over clear, other bits cleared", v, 8'h02);
    wr(1, 8'h00);
    wr(2, 8'h02);
    rd(2, v); chk("R11 writing 1 keeps", v, 8'h02);
    chk("R12 irq on masked-in flag", irq_o, 1);
    wr(5, 8'h00);
    chk("R12 irq low when mask cleared", irq_o, 0);
    wr(2, 8'h00);
  endtask

  task automatic t_modulo;
    logic [7:0] v;
    int n;
    wr(1, 8'h08); wr(4, 8'h09); wr(2, 8'h00);
    wr(1, 8'h03);
    n = 0;
    while (!dma_trig_o[0] && n < 50) begin @(negedge clk_i); n++; end
    rd(0, v); chk("R6 ch0 trigger at top", v, 8'h09);
    rd(2, v); chk("R6 no overflow before top", v[2], 0);
    @(negedge clk_i);
    rd(0, v); chk("R6 wrap to 0 after top", v, 8'h00);
    rd(2, v); chk("R6 overflow flag", v[2], 1);
    chk("R9 ch0 compare flag in modulo", v[0], 1);
    repeat (9) @(negedge clk_i);
    chk("R6 period ch0+1", dma_trig_o[0], 1);
    wr(1, 8'h02);
  endtask

  task automatic t_down;
    logic [7:0] v;
    wr(1, 8'h0A); wr(4, 8'h04); wr(2, 8'h00);
    wr(1, 8'h05);
    rd(0, v); chk("R7 start at 0", v, 8'h00);
    @(negedge clk_i);
    rd(0, v); chk("R7 reload ch0 value", v, 8'h04);
    rd(2, v); chk("R7 overflow at zero", v[2], 1);
    chk("R10 trigger in down mode", dma_trig_o[0], 1);
    @(negedge clk_i);
    rd(0, v); chk("R7 decrement", v, 8'h03);
    wr(1, 8'h08);
    rd(0, v); chk("R4 clear while running", v, 8'h00);
    rd(1, v); chk("R4 run and mode kept", v, 8'h05);
    @(negedge clk_i);
    rd(0, v); chk("R4 still counting in down mode", v, 8'h04);
    wr(1, 8'h04);
  endtask

  task automatic t_updown;
    logic [7:0] v;
    logic [7:0] seq [8] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd2, 8'd1, 8'd0, 8'd1};
    wr(1, 8'h08); wr(4, 8'h03); wr(6, 8'h02);
    wr(3, 8'h01); wr(5, 8'h00); wr(2, 8'h00);
    wr(1, 8'h07);
    for (int k = 0; k < 8; k++) begin
      if (k > 0) @(negedge clk_i);
      rd(0, v); chk($sformatf("R8 sequence step %0d", k), v, seq[k]);
      rd(2, v);
      if (k == 1) chk("R8 no flag on start from 0", v[0], 0);
      if (k == 3) begin
        chk("R9 ch1 compare flag in up/down", v[1], 1);
        chk("R10 ch0 trigger at top in up/down", dma_trig_o[0], 1);
      end
      if (k == 4) begin
        chk("R8 ch0 flag not on compare", v[0], 0);
        chk("R8 overflow not on compare", v[2], 0);
        chk("R12 no irq before turnaround", irq_o, 0);
      end
      if (k == 6) chk("R8 ch0 flag clear at bottom cycle", v[0], 0);
      if (k == 7) begin
        chk("R8 ch0 flag on turnaround", v[0], 1);
        chk("R8 overflow on turnaround", v[2], 1);
        chk("R12 irq from ch0", irq_o, 1);
      end
    end
    wr(1, 8'h06);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_regs();
    t_stopped();
    t_free();
    t_priority();
    t_modulo();
    t_down();
    t_updown();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule